// File: doc/BRIEF.md
# MSI Capability Register File

This block holds the software-visible registers of a PCI message-signalled-interrupt capability. It has the message control word, a low and an optional high message address, a 16-bit message data word, and optional per-vector mask and pending words. Configuration software reaches them through a 32-bit read/write port with byte enables. The port's byte address is compared against a capability base offset that comes in on a port. Three build-time parameters choose the vector capacity, whether 64-bit addressing is supported, and whether per-vector masking exists. Together these set the register layout and the size of the capability window.

Each field has its own write mask. A requested vector count larger than the capacity is pulled back to the capacity whenever a write leaves the capability enabled. The same kind of write also discards pending bits for vectors outside the enabled count. The message generator next to the block reads the decoded enable, vector count, address, data, mask and pending values. It sets and clears pending bits through dedicated strobes.

Top module: `msi_cap_regs`

## Requirements
- R1: After reset the enable bit, the requested-count field, both address words, the data word, the mask word and the pending word all read as zero, and `msi_en` is low.
- R2: The dword at the capability base holds the control word in bits 31:16: bit 16 enable, bits 19:17 log2 of the capacity, bits 22:20 requested log2 count, bit 23 64-bit capable, bit 24 masking capable. Bits 15:0 and 31:25 read zero, and the capacity and capability bits ignore writes.
- R3: The low address dword sits at base+4; bits 1:0 always read zero.
- R4: With 64-bit support the high address dword sits at base+8 and is fully writable; data then moves to base+0xC, mask to base+0x10 and pending to base+0x14 (in 32-bit mode these are base+8, +0xC, +0x10).
- R5: The data register keeps bits 15:0 of a write; bits 31:16 read zero.
- R6: Only mask bits 0 to capacity-1 are writable; higher mask bits read zero.
- R7: A write that leaves the enable bit set and carries a requested log2 count above the capacity log2 stores the capacity log2 instead. With enable clear, the value is stored unchanged.
- R8: After a write hitting the window that leaves enable set, pending bits at or above 2^(requested log2 count) are zero.
- R9: The window covers ceil(length/4) dwords from the base, where length is 0x0A, 0x0E, 0x14 or 0x18 bytes for 32-bit, 64-bit, 32-bit masked and 64-bit masked. Writes outside it change nothing, and reads outside it return zero.
- R10: A write updates only the byte lanes whose byte enable is set.
- R11: The outputs present the enable, the effective log2 count (the lesser of requested and capacity), the 64-bit address, the data, the mask and the pending bits. A `pend_set` bit sets its pending bit and a `pend_clr` bit clears it at the next edge.
- R12: The pending word ignores configuration writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cap_base | input | 8 | Byte offset of the capability (dword aligned) |
| cfg_addr | input | 8 | Byte address of the access (bits 1:0 ignored) |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 4 | Byte-lane enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| pend_set | input | VEC_CAP | Per-vector pending set strobes |
| pend_clr | input | VEC_CAP | Per-vector pending clear strobes |
| msi_en | output | 1 | Capability enable |
| msi_vec_log2 | output | 3 | Effective log2 of the enabled vector count |
| msg_addr | output | 64 | Message address (high word zero in 32-bit mode) |
| msg_data | output | 16 | Message data |
| vec_mask | output | VEC_CAP | Per-vector mask bits |
| vec_pend | output | VEC_CAP | Per-vector pending bits |

## Verification
Read data is combinational. It is valid in the same cycle the address is applied, so the bench samples it one nanosecond after driving the address at a falling edge. Writes, clamping, pending trimming and the pending set/clear strobes all take effect at the first rising edge after the stimulus. The bench therefore holds each stimulus for exactly one rising edge and checks the register or output at the following falling edge. Clamping and trimming happen at the same edge as the write that causes them, so the first read after that write already shows the corrected value.

// File: rtl/msi_cap_pkg.sv
`timescale 1ns/1ps
package msi_cap_pkg;

  // register select indices produced by the decoder
  localparam int SEL_CTRL = 0;
  localparam int SEL_ADLO = 1;
  localparam int SEL_ADHI = 2;
  localparam int SEL_DATA = 3;
  localparam int SEL_MASK = 4;
  localparam int SEL_PEND = 5;
  localparam int SEL_W    = 6;

  // capability length in bytes for the option pair
  function automatic logic [7:0] cap_len(input bit wide, input bit masked);
    case ({masked, wide})
      2'b00:   return 8'h0A;
      2'b01:   return 8'h0E;
      2'b10:   return 8'h14;
      default: return 8'h18;
    endcase
  endfunction

  // dwords touched by the capability window
  function automatic logic [5:0] cap_dwords(input bit wide, input bit masked);
    logic [7:0] len;
    len = cap_len(wide, masked) + 8'd3;
    return len[7:2];
  endfunction

  // byte-lane merge of a write into an old value
  function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[b*8 +: 8] = be[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
    return r;
  endfunction

  // smaller of requested and capable log2 count
  function automatic logic [2:0] eff_log2(input logic [2:0] req,
                                          input logic [2:0] cap);
    return (req > cap) ? cap : req;
  endfunction

  // is vector idx inside a block of 2^lg vectors
  function automatic logic vec_live(input int idx, input logic [2:0] lg);
    int cnt;
    cnt = 1 << lg;
    return idx < cnt;
  endfunction

endpackage

// File: rtl/msi_cap_decode.sv
`timescale 1ns/1ps
module msi_cap_decode
  import msi_cap_pkg::*;
#(
  parameter bit WIDE   = 1'b1,
  parameter bit MASKED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       acc_dw,
  input  logic [5:0]       base_dw,
  output logic             hit,
  output logic [SEL_W-1:0] sel
);

  localparam logic [5:0] NDW = cap_dwords(WIDE, MASKED);

  logic [5:0] rel;
  logic       below;

  assign rel   = acc_dw - base_dw;
  assign below = acc_dw < base_dw;

  always_comb begin
    sel = '0;
    hit = 1'b0;
    if (!below && rel < NDW) begin
      hit = 1'b1;
      case (rel)
        6'd0: sel[SEL_CTRL] = 1'b1;
        6'd1: sel[SEL_ADLO] = 1'b1;
        6'd2: if (WIDE) sel[SEL_ADHI] = 1'b1; else sel[SEL_DATA] = 1'b1;
        6'd3: if (WIDE) sel[SEL_DATA] = 1'b1; else sel[SEL_MASK] = 1'b1;
        6'd4: if (WIDE) sel[SEL_MASK] = 1'b1; else sel[SEL_PEND] = 1'b1;
        default: sel[SEL_PEND] = 1'b1;
      endcase
    end
  end

  // R9: at most one register picked, and only inside the window
  p_sel_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel) && (hit == (|sel)));

endmodule

// File: rtl/msi_cap_ctrl.sv
`timescale 1ns/1ps
module msi_cap_ctrl #(
  parameter logic [2:0] CAP_LOG2 = 3'd3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic       wd_en,
  input  logic [2:0] wd_req,
  output logic       en_q,
  output logic [2:0] req_q,
  output logic       en_d,
  output logic [2:0] req_d
);

  logic [2:0] req_raw;

  always_comb begin
    en_d    = wr ? wd_en  : en_q;
    req_raw = wr ? wd_req : req_q;
    // an enabled capability never keeps a count above its capacity
    req_d   = (en_d && req_raw > CAP_LOG2) ? CAP_LOG2 : req_raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      req_q <= '0;
    end else begin
      en_q  <= en_d;
      req_q <= req_d;
    end
  end

  // R7: while enabled the stored request is within capacity
  p_enable_clamped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (req_q <= CAP_LOG2));

endmodule

// File: rtl/msi_cap_vecbits.sv
`timescale 1ns/1ps
module msi_cap_vecbits
  import msi_cap_pkg::*;
#(
  parameter int NV = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mask_wr,
  input  logic [3:0]    mask_be,
  input  logic [31:0]   wdata,
  input  logic [NV-1:0] pend_set,
  input  logic [NV-1:0] pend_clr,
  input  logic          trim,
  input  logic [NV-1:0] keep,
  output logic [NV-1:0] mask_q,
  output logic [NV-1:0] pend_q
);

  logic [31:0]   mask_wide;
  logic [31:0]   mask_merged;
  logic [NV-1:0] mask_d;
  logic [NV-1:0] pend_d;

  always_comb begin
    mask_wide            = '0;
    mask_wide[NV-1:0]    = mask_q;
    mask_merged          = lane_merge(mask_wide, wdata, mask_be);
    mask_d               = mask_wr ? mask_merged[NV-1:0] : mask_q;
    pend_d               = (pend_q | pend_set) & ~pend_clr;
    if (trim) pend_d     = pend_d & keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end

  logic unused_bits;
  assign unused_bits = ^mask_merged;

  // R8: after a trimming write no pending bit survives outside the count
  p_trim_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trim |=> ((pend_q & ~$past(keep)) == '0));

  // R11: a clear strobe without a set strobe empties that pending bit
  p_pend_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_clr & ~pend_set)) |=> ((pend_q & $past(pend_clr & ~pend_set)) == '0));

endmodule

// File: rtl/msi_cap_regs.sv
`timescale 1ns/1ps
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter int VEC_CAP = 8,
  parameter bit WIDE    = 1'b1,
  parameter bit MASKED  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         cfg_cap_base,
  input  logic [7:0]         cfg_addr,
  input  logic               cfg_wr,
  input  logic [3:0]         cfg_be,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic [VEC_CAP-1:0] pend_set,
  input  logic [VEC_CAP-1:0] pend_clr,
  output logic               msi_en,
  output logic [2:0]         msi_vec_log2,
  output logic [63:0]        msg_addr,
  output logic [15:0]        msg_data,
  output logic [VEC_CAP-1:0] vec_mask,
  output logic [VEC_CAP-1:0] vec_pend
);

  localparam logic [2:0] CAP_LOG2 = 3'($clog2(VEC_CAP));

  // ---------------- decode ----------------
  logic             hit;
  logic [SEL_W-1:0] sel;
  logic             wr_hit;

  msi_cap_decode #(.WIDE(WIDE), .MASKED(MASKED)) u_decode (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_dw  (cfg_addr[7:2]),
    .base_dw (cfg_cap_base[7:2]),
    .hit     (hit),
    .sel     (sel)
  );

  assign wr_hit = cfg_wr && hit;

  // ---------------- control word ----------------
  logic       en_q, en_d;
  logic [2:0] req_q, req_d;

  msi_cap_ctrl #(.CAP_LOG2(CAP_LOG2)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cfg_wr && sel[SEL_CTRL] && cfg_be[2]),
    .wd_en  (cfg_wdata[16]),
    .wd_req (cfg_wdata[22:20]),
    .en_q   (en_q),
    .req_q  (req_q),
    .en_d   (en_d),
    .req_d  (req_d)
  );

  // ---------------- address and data ----------------
  logic [31:2] adlo_q;
  logic [31:0] adhi_q;
  logic [15:0] data_q;
  logic [31:0] adlo_m;
  logic [31:0] data_m;

  assign adlo_m = lane_merge({adlo_q, 2'b00}, cfg_wdata, cfg_be);
  assign data_m = lane_merge({16'h0, data_q}, cfg_wdata, cfg_be);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adlo_q <= '0;
      data_q <= '0;
    end else begin
      if (cfg_wr && sel[SEL_ADLO]) adlo_q <= adlo_m[31:2];
      if (cfg_wr && sel[SEL_DATA]) data_q <= data_m[15:0];
    end
  end

  generate
    if (WIDE) begin : g_hi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       adhi_q <= '0;
        else if (cfg_wr && sel[SEL_ADHI]) adhi_q <= lane_merge(adhi_q, cfg_wdata, cfg_be);
      end
    end else begin : g_no_hi
      assign adhi_q = '0;
    end
  endgenerate

  // ---------------- mask and pending ----------------
  logic [VEC_CAP-1:0] keep;
  logic [VEC_CAP-1:0] mask_q;
  logic [VEC_CAP-1:0] pend_q;
  logic               trim;

  always_comb begin
    for (int i = 0; i < VEC_CAP; i++) keep[i] = vec_live(i, req_d);
  end

  assign trim = wr_hit && en_d;

  generate
    if (MASKED) begin : g_vec
      msi_cap_vecbits #(.NV(VEC_CAP)) u_vecbits (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask_wr  (cfg_wr && sel[SEL_MASK]),
        .mask_be  (cfg_be),
        .wdata    (cfg_wdata),
        .pend_set (pend_set),
        .pend_clr (pend_clr),
        .trim     (trim),
        .keep     (keep),
        .mask_q   (mask_q),
        .pend_q   (pend_q)
      );
    end else begin : g_no_vec
      assign mask_q = '0;
      assign pend_q = '0;
    end
  endgenerate

  // ---------------- read mux ----------------
  logic [31:0] ctrl_word;
  logic [31:0] mask_rd;
  logic [31:0] pend_rd;

  always_comb begin
    ctrl_word = {7'h0, MASKED, WIDE, req_q, CAP_LOG2, en_q, 16'h0000};
    mask_rd   = '0;
    pend_rd   = '0;
    mask_rd[VEC_CAP-1:0] = mask_q;
    pend_rd[VEC_CAP-1:0] = pend_q;
    cfg_rdata = '0;
    if (sel[SEL_CTRL]) cfg_rdata = ctrl_word;
    if (sel[SEL_ADLO]) cfg_rdata = {adlo_q, 2'b00};
    if (sel[SEL_ADHI]) cfg_rdata = adhi_q;
    if (sel[SEL_DATA]) cfg_rdata = {16'h0000, data_q};
    if (sel[SEL_MASK]) cfg_rdata = mask_rd;
    if (sel[SEL_PEND]) cfg_rdata = pend_rd;
  end

  // ---------------- exports ----------------
  assign msi_en       = en_q;
  assign msi_vec_log2 = eff_log2(req_q, CAP_LOG2);
  assign msg_addr     = {adhi_q, adlo_q, 2'b00};
  assign msg_data     = data_q;
  assign vec_mask     = mask_q;
  assign vec_pend     = pend_q;

  logic unused_bits;
  assign unused_bits = ^{cfg_cap_base[1:0], cfg_addr[1:0], adlo_m[1:0], data_m[31:16]};

  // R9: without a write into the window the address and data hold
  p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> ($stable(adlo_q) && $stable(adhi_q) && $stable(data_q)));

endmodule

// File: tb/test_msi_cap_regs.sv
`timescale 1ns/1ps
module test_msi_cap_regs;

  localparam int NV = 8;
  localparam logic [7:0] BASE = 8'h50;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    cfg_addr = '0;
  logic          cfg_wr = 1'b0;
  logic [3:0]    cfg_be = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic [NV-1:0] pend_set = '0;
  logic [NV-1:0] pend_clr = '0;
  logic          msi_en;
  logic [2:0]    msi_vec_log2;
  logic [63:0]   msg_addr;
  logic [15:0]   msg_data;
  logic [NV-1:0] vec_mask;
  logic [NV-1:0] vec_pend;

  always #2.5 clk = ~clk;

  msi_cap_regs #(.VEC_CAP(NV), .WIDE(1'b1), .MASKED(1'b1)) i_msi_cap_regs (
    .clk(clk), .rst_n(rst_n), .cfg_cap_base(BASE), .cfg_addr(cfg_addr),
    .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pend_set(pend_set), .pend_clr(pend_clr), .msi_en(msi_en),
    .msi_vec_log2(msi_vec_log2), .msg_addr(msg_addr), .msg_data(msg_data),
    .vec_mask(vec_mask), .vec_pend(vec_pend)
  );

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic        wr;
    logic [7:0]  a;
    logic [3:0]  be;
    logic [31:0] d;
    logic [31:0] x;
    logic [7:0]  rq;
  } op_t;

  // control dword: en 16, capable 19:17 (=3), request 22:20, wide 23, masked 24
  localparam op_t OPS [27] = '{
    '{1'b0, 8'h50, 4'h0, 32'h0,        32'h0186_0000, 8'd2 },  // R2 reset layout
    '{1'b0, 8'h54, 4'h0, 32'h0,        32'h0,         8'd1 },  // R1
    '{1'b0, 8'h58, 4'h0, 32'h0,        32'h0,         8'd1 },  // R1
    '{1'b0, 8'h5C, 4'h0, 32'h0,        32'h0,         8'd1 },  // R1
    '{1'b0, 8'h60, 4'h0, 32'h0,        32'h0,         8'd1 },  // R1
    '{1'b0, 8'h64, 4'h0, 32'h0,        32'h0,         8'd1 },  // R1
    '{1'b1, 8'h54, 4'hF, 32'hDEADBEEF, 32'h0,         8'd3 },
    '{1'b0, 8'h54, 4'h0, 32'h0,        32'hDEADBEEC, 8'd3 },  // R3
    '{1'b1, 8'h58, 4'hF, 32'h12345678, 32'h0,         8'd4 },
    '{1'b0, 8'h58, 4'h0, 32'h0,        32'h12345678, 8'd4 },  // R4
    '{1'b1, 8'h5C, 4'hF, 32'hABCD9876, 32'h0,         8'd5 },
    '{1'b0, 8'h5C, 4'h0, 32'h0,        32'h0000_9876, 8'd5 },  // R5
    '{1'b1, 8'h60, 4'hF, 32'hFFFFFFFF, 32'h0,         8'd6 },
    '{1'b0, 8'h60, 4'h0, 32'h0,        32'h0000_00FF, 8'd6 },  // R6
    '{1'b1, 8'h64, 4'hF, 32'hFFFFFFFF, 32'h0,         8'd12},
    '{1'b0, 8'h64, 4'h0, 32'h0,        32'h0,         8'd12},  // R12
    '{1'b1, 8'h50, 4'hF, 32'hFFFFFFFF, 32'h0,         8'd7 },
    '{1'b0, 8'h50, 4'h0, 32'h0,        32'h01B7_0000, 8'd7 },  // R7 clamp to 3
    '{1'b1, 8'h54, 4'h2, 32'h0000_5500, 32'h0,        8'd10},
    '{1'b0, 8'h54, 4'h0, 32'h0,        32'hDEAD55EC, 8'd10},  // R10
    '{1'b1, 8'h68, 4'hF, 32'hFFFFFFFF, 32'h0,         8'd9 },
    '{1'b0, 8'h68, 4'h0, 32'h0,        32'h0,         8'd9 },  // R9 above window
    '{1'b1, 8'h4C, 4'hF, 32'hFFFFFFFF, 32'h0,         8'd9 },
    '{1'b0, 8'h4C, 4'h0, 32'h0,        32'h0,         8'd9 },  // R9 below window
    '{1'b1, 8'h50, 4'h4, 32'h0070_0000, 32'h0,        8'd7 },
    '{1'b0, 8'h50, 4'h0, 32'h0,        32'h01F6_0000, 8'd7 },  // R7 disabled: no clamp
    '{1'b0, 8'h54, 4'h0, 32'h0,        32'hDEAD55EC, 8'd9 }   // R9 outside writes left it
  };

  task automatic chk(input int rq, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input int rq);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(rq, {32'h0, cfg_rdata}, {32'h0, exp});
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(1, {63'h0, msi_en}, 64'h0);  // R1 enable low after reset

    foreach (OPS[k]) begin
      if (OPS[k].wr) wr(OPS[k].a, OPS[k].be, OPS[k].d);
      else           rd(OPS[k].a, OPS[k].x, int'(OPS[k].rq));
    end
    // R11 disabled with an over-sized request: effective count is capacity
    chk(11, {63'h0, msi_en}, 64'h0);
    chk(11, {61'h0, msi_vec_log2}, 64'd3);

    // R11 pending set strobe
    @(negedge clk); pend_set = 8'hFF;
    @(negedge clk); pend_set = 8'h00;
    chk(11, {56'h0, vec_pend}, 64'hFF);
    rd(8'h64, 32'h0000_00FF, 11);

    // R8 enable with two vectors trims pending to bits 1:0
    wr(8'h50, 4'h4, 32'h0011_0000);
    rd(8'h50, 32'h0197_0000, 7);
    rd(8'h64, 32'h0000_0003, 8);
    chk(11, {63'h0, msi_en}, 64'h1);
    chk(11, {61'h0, msi_vec_log2}, 64'd1);
    chk(11, msg_addr, 64'h12345678_DEAD55EC);
    chk(11, {48'h0, msg_data}, 64'h9876);
    chk(11, {56'h0, vec_mask}, 64'hFF);
    chk(11, {56'h0, vec_pend}, 64'h03);

    // R11 pending clear strobe
    @(negedge clk); pend_clr = 8'h01;
    @(negedge clk); pend_clr = 8'h00;
    chk(11, {56'h0, vec_pend}, 64'h02);

    // R8 single vector: bit 1 dropped
    wr(8'h50, 4'h4, 32'h0001_0000);
    chk(8, {56'h0, vec_pend}, 64'h00);

    // R10 / R6 partial mask write
    wr(8'h60, 4'h1, 32'hFFFF_FF55);
    rd(8'h60, 32'h0000_0055, 10);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(8'h50, 32'h0186_0000, 1);
    rd(8'h54, 32'h0, 1);
    rd(8'h58, 32'h0, 1);
    rd(8'h5C, 32'h0, 1);
    rd(8'h60, 32'h0, 1);
    rd(8'h64, 32'h0, 1);
    chk(1, {63'h0, msi_en}, 64'h0);

    summary();
  end

endmodule